// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block turns up to 24 asynchronous external interrupt lines into request bits for a downstream interrupt controller. Each line is brought into the clock domain through a two-stage synchroniser. A per-line trigger mode then decides whether the request is level sensitive (active low or active high) or edge sensitive (falling, rising or either edge). A level mode holds the request while its condition lasts. An edge mode gives a request pulse one clock long.

The trigger modes sit in 32-bit configuration words that software reaches over a simple register bus. Each word covers eight lines. Every line owns a 4-bit slot, and only the low three bits of that slot are stored. Byte write strobes let software change the modes of some lines without touching their neighbours. When a line's mode field is written, its edge history is reloaded, so reprogramming a line never produces a false edge.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every mode field reads 0, which means low level. Every configuration word reads 0x00000000.
- R2: Line p lives in word p/8, in bits [4*(p%8)+2 : 4*(p%8)]. Bit 4*(p%8)+3 always reads 0.
- R3: A write updates only the fields in the bytes whose strobe bit is set, in the addressed word. A write or read at a word index of 3 or more has no effect, and such a read returns 0.
- R4: A change on a line is seen at irq_req after the second rising clock edge that follows it.
- R5: Mode 000 (low level): the request is high for as long as the synchronised line is 0.
- R6: Mode 001 (high level): the request is high for as long as the synchronised line is 1.
- R7: Modes 010 and 011 (falling edge): a 1-to-0 transition of the synchronised line gives a request pulse exactly one cycle long.
- R8: Modes 100 and 101 (rising edge): a 0-to-1 transition gives a request pulse exactly one cycle long.
- R9: Modes 110 and 111 (both edges): every transition gives a request pulse one cycle long.
- R10: A write to a line's field reloads that line's edge history. A transition that reaches the synchronised stage on the same clock edge as the write gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin | input | 24 | Asynchronous external interrupt lines |
| bus_addr | input | 2 | Configuration word index |
| bus_we | input | 1 | Write enable |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq_req | output | 24 | One request bit per line |

## Verification
Directed sequences put one line in each mode and drive single transitions. These show the difference between a held level and a one-cycle pulse, and they pin down the two-edge synchroniser latency. A write that lands on the same edge as an incoming transition shows whether the edge history is reloaded. Partial-strobe and out-of-range writes, followed by read-back, show per-line field isolation. A long stretch of random line toggling under random modes is compared clock by clock against a behavioural model. This exposes wrong mode decoding and wrong lane mapping on any line.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int MODE_W = 3;
  localparam int SLOT_W = 4;

  typedef enum logic [2:0] {
    TRG_LOW  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_FALL = 3'd2,
    TRG_RISE = 3'd3,
    TRG_BOTH = 3'd4
  } trig_kind_e;

  function automatic trig_kind_e decode_mode(input logic [MODE_W-1:0] m);
    case (m[2:1])
      2'b00:   decode_mode = m[0] ? TRG_HIGH : TRG_LOW;
      2'b01:   decode_mode = TRG_FALL;
      2'b10:   decode_mode = TRG_RISE;
      default: decode_mode = TRG_BOTH;
    endcase
  endfunction
endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ext_irq_cfg_regs.sv
module ext_irq_cfg_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PINS_PER_WORD = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W/8-1:0]        bus_wstrb,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [MODE_W*NUM_PINS-1:0] mode_flat,
  output logic [NUM_PINS-1:0]        field_wr
);
  localparam int NUM_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

  logic [MODE_W-1:0] mode_q [NUM_PINS];
  logic [MODE_W-1:0] mode_d [NUM_PINS];
  logic [NUM_PINS-1:0] hit;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      hit[p] = bus_we && (int'(bus_addr) == p / PINS_PER_WORD)
               && bus_wstrb[(SLOT_W * (p % PINS_PER_WORD)) / 8];
      mode_d[p] = hit[p] ? bus_wdata[SLOT_W * (p % PINS_PER_WORD) +: MODE_W]
                         : mode_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) mode_q[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) mode_q[p] <= mode_d[p];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(bus_addr) == p / PINS_PER_WORD)
        bus_rdata[SLOT_W * (p % PINS_PER_WORD) +: MODE_W] = mode_q[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) mode_flat[MODE_W*p +: MODE_W] = mode_q[p];
  end

  assign field_wr = hit;

  // an out-of-range write must leave every stored field alone
  p_oob_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) >= NUM_WORDS) |=> $stable(mode_flat));

  // a write to word 0 must leave all lines outside word 0 alone
  p_word_isolation_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |=>
      $stable(mode_flat[MODE_W*NUM_PINS-1:MODE_W*PINS_PER_WORD]));
endmodule

// File: rtl/ext_irq_pin_detect.sv
module ext_irq_pin_detect
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              reload_i,
  output logic              req_o
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;
  trig_kind_e kind;

  always_comb begin
    meta_d = pin_i;
    sync_d = meta_q;
    prev_d = reload_i ? meta_q : sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    kind = decode_mode(mode_i);
    case (kind)
      TRG_LOW:  req_o = ~sync_q;
      TRG_HIGH: req_o = sync_q;
      TRG_FALL: req_o = prev_q & ~sync_q;
      TRG_RISE: req_o = sync_q & ~prev_q;
      default:  req_o = sync_q ^ prev_q;
    endcase
  end

  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TRG_HIGH && $past(kind == TRG_HIGH)) |-> (req_o == $past(meta_q)));

  p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TRG_FALL && req_o) |=> !(kind == TRG_FALL && req_o));

  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TRG_RISE && req_o) |=> !(kind == TRG_RISE && req_o));

  p_reload_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> !(req_o && kind != TRG_LOW && kind != TRG_HIGH));
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PINS_PER_WORD = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] irq_req
);
  logic rst_n_int;
  logic [MODE_W*NUM_PINS-1:0] mode_flat;
  logic [NUM_PINS-1:0] field_wr;

  ext_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ext_irq_cfg_regs #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_WORD (PINS_PER_WORD),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wstrb (bus_wstrb),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_flat (mode_flat),
    .field_wr  (field_wr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ext_irq_pin_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .pin_i    (ext_pin[p]),
      .mode_i   (mode_flat[MODE_W*p +: MODE_W]),
      .reload_i (field_wr[p]),
      .req_o    (irq_req[p])
    );
  end
endmodule

// File: tb/tb_ext_irq_trigger.sv
module tb_ext_irq_trigger;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] ext_pin = '0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [3:0] bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit compare_on = 0;

  // behavioural reference state
  int m_meta [NP];
  int m_sync [NP];
  int m_prev [NP];
  int m_mode [NP];

  ext_irq_trigger dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  initial for (int p = 0; p < NP; p++) begin
    m_meta[p] = 0; m_sync[p] = 0; m_prev[p] = 0; m_mode[p] = 0;
  end

  function automatic bit model_req(int p);
    int m = m_mode[p];
    if (m == 0) return m_sync[p] == 0;
    if (m == 1) return m_sync[p] == 1;
    if (m < 4)  return m_prev[p] == 1 && m_sync[p] == 0;
    if (m < 6)  return m_prev[p] == 0 && m_sync[p] == 1;
    return m_prev[p] != m_sync[p];
  endfunction

  function automatic string mode_tag(int m);
    if (m == 0) return "R5";
    if (m == 1) return "R6";
    if (m < 4)  return "R7";
    if (m < 6)  return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] model_word(int w);
    logic [31:0] v = '0;
    if (w > 2) return v;
    for (int s = 0; s < 8; s++) v[4*s +: 3] = m_mode[w*8+s][2:0];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        bit wr;
        wr = bus_we && int'(bus_addr) == p/8 && bus_wstrb[(p%8)/2];
        m_prev[p] = wr ? m_meta[p] : m_sync[p];
        m_sync[p] = m_meta[p];
        m_meta[p] = ext_pin[p];
        if (wr) m_mode[p] = bus_wdata[4*(p%8) +: 3];
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      logic [NP-1:0] exp;
      for (int p = 0; p < NP; p++) exp[p] = model_req(p);
      checks++;
      if (irq_req !== exp) begin
        int bad = 0;
        for (int p = NP-1; p >= 0; p--) if (irq_req[p] !== exp[p]) bad = p;
        errors++;
        $display("FAIL %s (R4 latency) pin %0d: irq_req=%h expected %h",
                 mode_tag(m_mode[bad]), bad, irq_req, exp);
      end
    end
  end

  task automatic bus_write(input int w, input logic [3:0] strb, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = w[1:0]; bus_we = 1'b1; bus_wstrb = strb; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0; bus_wstrb = '0;
  endtask

  task automatic bus_check(input int w, input string tag);
    logic [31:0] exp;
    @(negedge clk); #1;
    bus_addr = w[1:0];
    #1;
    exp = model_word(w);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s word %0d: rdata=%h expected %h", tag, w, bus_rdata, exp);
    end
  endtask

  task automatic pin_check(input int p, input bit exp, input string tag);
    checks++;
    if (irq_req[p] !== exp) begin
      errors++;
      $display("FAIL %s pin %0d: irq_req=%b expected %b", tag, p, irq_req[p], exp);
    end
  endtask

  task automatic set_pin(input int p, input bit v);
    @(negedge clk); #1;
    ext_pin[p] = v;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_on = 1;
    // R1: reset state
    for (int w = 0; w < 3; w++) bus_check(w, "R1");
    checks++;
    if (irq_req !== {NP{1'b1}}) begin
      errors++;
      $display("FAIL R1 irq_req=%h expected %h", irq_req, {NP{1'b1}});
    end

    // R2: field placement, bit 3 of each slot dropped
    bus_write(1, 4'hF, 32'hFEDC_BA98);
    bus_check(1, "R2");
    bus_write(2, 4'hF, 32'h7654_3210);
    bus_check(2, "R2");

    // R3: byte strobes and out-of-range accesses
    bus_write(0, 4'b0100, 32'h5555_5555);
    bus_check(0, "R3");
    bus_check(1, "R3");
    bus_write(3, 4'hF, 32'hFFFF_FFFF);
    bus_check(3, "R3");
    bus_check(0, "R3");
    bus_check(2, "R3");

    // R4/R6: pin 0 in high level, latency of two edges
    bus_write(0, 4'h1, 32'h0000_0001);
    set_pin(0, 1);
    @(negedge clk); pin_check(0, 0, "R4");
    @(negedge clk); pin_check(0, 1, "R4");
    repeat (3) @(negedge clk); pin_check(0, 1, "R6");
    // R5: pin 1 low level held while the line is low
    pin_check(1, 1, "R5");
    set_pin(1, 1);
    repeat (2) @(negedge clk); pin_check(1, 0, "R5");
    // R8: rising edge gives one pulse on pin 0
    set_pin(0, 0);
    bus_write(0, 4'h1, 32'h0000_0004);
    repeat (3) @(negedge clk);
    set_pin(0, 1);
    @(negedge clk);
    @(negedge clk); pin_check(0, 1, "R8");
    @(negedge clk); pin_check(0, 0, "R8");
    // R7: falling edge on pin 0 with mode 011
    bus_write(0, 4'h1, 32'h0000_0003);
    repeat (3) @(negedge clk);
    set_pin(0, 0);
    @(negedge clk);
    @(negedge clk); pin_check(0, 1, "R7");
    @(negedge clk); pin_check(0, 0, "R7");
    // R9: both edges with mode 111
    bus_write(0, 4'h1, 32'h0000_0007);
    repeat (3) @(negedge clk);
    set_pin(0, 1);
    @(negedge clk);
    @(negedge clk); pin_check(0, 1, "R9");
    @(negedge clk); pin_check(0, 0, "R9");

    // R10: transition reaches sync stage on the write edge, no pulse
    bus_write(0, 4'h1, 32'h0000_0004);
    set_pin(0, 0);
    repeat (4) @(negedge clk);
    #1 ext_pin[0] = 1'b1;
    @(negedge clk); #1;
    bus_addr = 2'd0; bus_we = 1'b1; bus_wstrb = 4'h1; bus_wdata = 32'h0000_0004;
    @(negedge clk); pin_check(0, 0, "R10");
    #1 bus_we = 1'b0; bus_wstrb = '0;
    @(negedge clk); pin_check(0, 0, "R10");

    // random stress against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if ((i % 40) == 0) begin
        bus_addr = 2'($urandom_range(0, 3));
        bus_we = 1'b1;
        bus_wstrb = 4'($urandom);
        bus_wdata = $urandom;
      end else begin
        bus_we = 1'b0;
      end
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 3) == 0) ext_pin[p] = ~ext_pin[p];
    end
    @(negedge clk); #1 bus_we = 1'b0;
    for (int w = 0; w < 4; w++) bus_check(w, "R3");
    repeat (3) @(negedge clk);
    compare_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule